// File: doc/BRIEF.md
# Receive Descriptor Completion Engine

This block finishes the handling of one received frame when a network receiver works from a ring of descriptors in host memory. A start pulse hands it the ring base, the index of the current descriptor, the frame length, the frame class (broadcast, multicast, physical match) and a checksum word. The engine fetches the 16-byte descriptor over a simple 32-bit request/acknowledge memory port. A descriptor holds a status/size word, a tag word, and the low and high halves of a 64-bit buffer address. The engine then decides whether the frame can be stored at all.

A frame is stored only when the host has given the descriptor to the receiver and its buffer can hold the padded frame plus its 4-byte checksum. In that case the frame words are taken from a valid/ready stream and written to the buffer, with short frames zero-padded to the minimum length. The checksum follows directly behind the frame bytes. The tag word and then the status word are written back, the receive-OK pulse fires and the next index is presented. In any other case nothing is written. The frame's stream words are still drained, the overflow and missed-frame pulses fire and the index stays put.

Top module: `rx_desc_engine`

## Requirements
- R1: After a start pulse the engine reads the four descriptor words, in ascending order, at ring_base + 16*desc_idx + 0, 4, 8 and 12. The buffer address is {word at +12, word at +8} with its two low bits forced to zero.
- R2: If status bit 31 (owned by receiver) is clear, the engine issues no memory write. It raises ovf_irq and miss_inc together for one cycle, does not raise rx_ok, and sets next_idx to desc_idx.
- R3: Let P be the padded length. If P + 4 is greater than the size in status bits 12:0, the frame is dropped exactly as in R2. A size equal to P + 4 is accepted.
- R4: Frame byte i is taken from stream word i/4, lane i%4 (bits 8*(i%4)+7 : 8*(i%4)). It is written to buffer + i using ascending word addresses. Stream lanes past the frame length are not stored.
- R5: The padded length P is the larger of frame_len and 60. Bytes from frame_len up to P are stored as zero.
- R6: crc_word is stored at buffer + P, least significant byte first. Byte enables cover exactly bytes 0 to P+3, so buffer bytes past P+3 are left unchanged.
- R7: On success, the tag word is written back first with bit 16 cleared. The status word is then written last. It has bit 31 cleared and bits 29 and 28 set. Bit 26 is ORed with multicast, bit 25 with physical match and bit 24 with broadcast. Bits 12:0 are set to P + 4, and bits 30 and 27:13 are kept.
- R8: After the status write is acknowledged, rx_ok pulses for one cycle and busy falls in the same cycle. next_idx becomes desc_idx + 1, or 0 if status bit 30 (end of ring) was set.
- R9: A dropped frame still has its ceil(frame_len/4) stream words accepted and discarded before busy falls.
- R10: A memory request, once raised, keeps its address, direction and byte enables stable until mem_ack.
- R11: While busy, a start pulse is ignored. When idle, the engine raises no memory request and no in_ready. After reset it is idle, all pulses are low and next_idx is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin handling one frame (accepted when idle) |
| ring_base | input | 64 | Byte address of descriptor 0 |
| desc_idx | input | IDX_W | Current descriptor index |
| frame_len | input | 13 | Frame length in bytes |
| cls_bcast | input | 1 | Frame is broadcast |
| cls_mcast | input | 1 | Frame is multicast |
| cls_phys | input | 1 | Frame matched the station address |
| crc_word | input | 32 | Checksum word stored after the frame |
| in_valid | input | 1 | Stream word available |
| in_data | input | 32 | Stream word, byte 0 in the low lane |
| in_ready | output | 1 | Stream word taken this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Frame in progress |
| rx_ok | output | 1 | One-cycle pulse: frame stored, descriptor returned |
| ovf_irq | output | 1 | One-cycle pulse: frame dropped, overflow |
| miss_inc | output | 1 | One-cycle pulse: increment missed-frame count |
| next_idx | output | IDX_W | Descriptor index for the next frame |

## Verification
A corrupted word counter or a wrong padded length shows up at the ports within the same frame. It appears as a checksum landing at the wrong offset, as byte enables spilling into the guard bytes behind it, or as a status length that disagrees with the stored data. A wrong ownership or capacity decision shows up within about six cycles of the descriptor fetch. It appears as a write that should not happen, or as a missing overflow pulse. A stream-draining error desynchronises the following frame, so its data comparison fails one frame later.

// File: rtl/rx_desc_engine.sv
module rx_desc_engine #(
  parameter int IDX_W   = 8,
  parameter int MIN_LEN = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [63:0]      ring_base,
  input  logic [IDX_W-1:0] desc_idx,
  input  logic [12:0]      frame_len,
  input  logic             cls_bcast,
  input  logic             cls_mcast,
  input  logic             cls_phys,
  input  logic [31:0]      crc_word,
  input  logic             in_valid,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [63:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_be,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             busy,
  output logic             rx_ok,
  output logic             ovf_irq,
  output logic             miss_inc,
  output logic [IDX_W-1:0] next_idx
);
  localparam int CW = 14;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_DEC, S_DRAIN, S_WR, S_WB1, S_WB0} st_t;
  st_t st;

  logic [63:0]      base_q;
  logic [IDX_W-1:0] idx_q;
  logic [12:0]      len_q;
  logic             b_q, m_q, p_q;
  logic [31:0]      crc_q;
  logic [31:0]      w0, w1, lo, hi;
  logic [1:0]       rw;
  logic [CW-1:0]    k;
  logic             hold;
  logic [31:0]      dbuf;

  logic [CW-1:0] plen, tot, nd, nw;
  logic          drop;
  logic [63:0]   desc_addr, buf_addr;
  logic [31:0]   w0_new, w1_new, wr_data;
  logic [3:0]    wr_be;
  logic [15:0]   pos;
  logic [1:0]    csel;

  assign plen = (len_q < 13'(MIN_LEN)) ? CW'(MIN_LEN) : CW'(len_q);
  assign tot  = plen + CW'(4);
  assign nd   = (CW'(len_q) + CW'(3)) >> 2;
  assign nw   = (tot + CW'(3)) >> 2;
  assign drop = !w0[31] || (tot > CW'(w0[12:0]));

  assign desc_addr = base_q + (64'(idx_q) << 4);
  assign buf_addr  = {hi, lo[31:2], 2'b00};

  assign w0_new = {1'b0, w0[30], 2'b11, w0[27], w0[26] | m_q, w0[25] | p_q,
                   w0[24] | b_q, w0[23:13], tot[12:0]};
  assign w1_new = w1 & ~(32'h1 << 16);

  always_comb begin
    wr_data = '0;
    wr_be   = '0;
    pos     = '0;
    csel    = '0;
    for (int b = 0; b < 4; b++) begin
      pos  = {k, 2'b00} + 16'(b);
      csel = 2'(pos - 16'(plen));
      if (pos < 16'(len_q))     wr_data[8*b +: 8] = dbuf[8*b +: 8];
      else if (pos < 16'(plen)) wr_data[8*b +: 8] = 8'h00;
      else                      wr_data[8*b +: 8] = 8'(crc_q >> {csel, 3'b000});
      wr_be[b] = pos < 16'(tot);
    end
  end

  assign busy     = st != S_IDLE;
  assign in_ready = (st == S_DRAIN) || (st == S_WR && !hold && k < nd);
  assign mem_req  = (st == S_RD) || (st == S_WR && (hold || k >= nd)) ||
                    (st == S_WB1) || (st == S_WB0);
  assign mem_we   = (st == S_WR) || (st == S_WB1) || (st == S_WB0);
  assign mem_be   = (st == S_WR) ? wr_be : 4'hF;

  always_comb begin
    case (st)
      S_RD:    mem_addr = desc_addr + {60'd0, rw, 2'b00};
      S_WR:    mem_addr = buf_addr + (64'(k) << 2);
      S_WB1:   mem_addr = desc_addr + 64'd4;
      default: mem_addr = desc_addr;
    endcase
    case (st)
      S_WB0:   mem_wdata = w0_new;
      S_WB1:   mem_wdata = w1_new;
      default: mem_wdata = wr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      base_q <= '0; idx_q <= '0; len_q <= '0;
      b_q <= 1'b0; m_q <= 1'b0; p_q <= 1'b0; crc_q <= '0;
      w0 <= '0; w1 <= '0; lo <= '0; hi <= '0;
      rw <= '0; k <= '0; hold <= 1'b0; dbuf <= '0;
      rx_ok <= 1'b0; ovf_irq <= 1'b0; miss_inc <= 1'b0;
      next_idx <= '0;
    end else begin
      rx_ok <= 1'b0;
      ovf_irq <= 1'b0;
      miss_inc <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base_q <= ring_base; idx_q <= desc_idx; len_q <= frame_len;
          b_q <= cls_bcast; m_q <= cls_mcast; p_q <= cls_phys; crc_q <= crc_word;
          rw <= '0;
          st <= S_RD;
        end
        S_RD: if (mem_ack) begin
          case (rw)
            2'd0: w0 <= mem_rdata;
            2'd1: w1 <= mem_rdata;
            2'd2: lo <= mem_rdata;
            default: hi <= mem_rdata;
          endcase
          rw <= rw + 2'd1;
          if (rw == 2'd3) st <= S_DEC;
        end
        S_DEC: begin
          k <= '0;
          hold <= 1'b0;
          if (drop) begin
            ovf_irq <= 1'b1;
            miss_inc <= 1'b1;
            next_idx <= idx_q;
            st <= (nd == '0) ? S_IDLE : S_DRAIN;
          end else begin
            st <= S_WR;
          end
        end
        S_DRAIN: if (in_valid) begin
          k <= k + CW'(1);
          if (k == nd - CW'(1)) st <= S_IDLE;
        end
        S_WR: begin
          if (in_ready && in_valid) begin
            dbuf <= in_data;
            hold <= 1'b1;
          end else if (mem_ack) begin
            hold <= 1'b0;
            k <= k + CW'(1);
            if (k == nw - CW'(1)) st <= S_WB1;
          end
        end
        S_WB1: if (mem_ack) st <= S_WB0;
        S_WB0: if (mem_ack) begin
          rx_ok <= 1'b1;
          next_idx <= w0[30] ? '0 : idx_q + IDX_W'(1);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_engine_chk.sv
module rx_desc_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        mem_ack,
  input logic        in_ready,
  input logic        busy,
  input logic        rx_ok,
  input logic        ovf_irq,
  input logic        miss_inc
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

  assert_drop_pulses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> miss_inc && !rx_ok);

  assert_miss_with_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_inc |-> ovf_irq);

  assert_be_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !in_ready);

  assert_ok_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok |-> !busy && $past(mem_req && mem_we && mem_ack));
endmodule

bind rx_desc_engine rx_desc_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .mem_ack(mem_ack), .in_ready(in_ready), .busy(busy),
  .rx_ok(rx_ok), .ovf_irq(ovf_irq), .miss_inc(miss_inc)
);

// File: tb/tb_rx_desc_engine.sv
module tb_rx_desc_engine;
  localparam int IDX_W = 8;
  localparam logic [63:0] BASE = 64'h40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0;
  logic [63:0] ring_base = BASE;
  logic [IDX_W-1:0] desc_idx = '0;
  logic [12:0] frame_len = '0;
  logic cls_bcast = 1'b0, cls_mcast = 1'b0, cls_phys = 1'b0;
  logic [31:0] crc_word = '0;
  logic in_valid, in_ready;
  logic [31:0] in_data;
  logic mem_req, mem_we, mem_ack;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic busy, rx_ok, ovf_irq, miss_inc;
  logic [IDX_W-1:0] next_idx;

  rx_desc_engine #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ring_base(ring_base), .desc_idx(desc_idx),
    .frame_len(frame_len), .cls_bcast(cls_bcast), .cls_mcast(cls_mcast), .cls_phys(cls_phys),
    .crc_word(crc_word), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .rx_ok(rx_ok),
    .ovf_irq(ovf_irq), .miss_inc(miss_inc), .next_idx(next_idx)
  );

  logic [31:0] mem [0:1023];
  logic [63:0] rd_log [0:255];
  logic [63:0] wr_log [0:255];
  int rd_n = 0, wr_n = 0, ok_n = 0;
  logic lat = 1'b0;
  logic ack_q = 1'b0;
  assign mem_ack = ack_q;
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    ack_q <= 1'b0;
    if (rx_ok) ok_n <= ok_n + 1;
    if (mem_req && !ack_q) begin
      if (lat) begin
        ack_q <= 1'b1;
        lat <= 1'b0;
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          wr_log[wr_n[7:0]] <= mem_addr;
          wr_n <= wr_n + 1;
        end else begin
          rd_log[rd_n[7:0]] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end else lat <= 1'b1;
    end
  end

  logic [31:0] src [0:1023];
  int src_n = 0, src_i = 0;
  logic src_rst = 1'b0;
  assign in_valid = src_i < src_n;
  assign in_data = in_valid ? src[src_i[9:0]] : 32'h0;
  always @(posedge clk) begin
    if (src_rst) src_i <= 0;
    else if (in_valid && in_ready) src_i <= src_i + 1;
  end

  int checks = 0, errors = 0, cyc = 0;
  bit got_ok, got_ovf, got_miss;
  logic [IDX_W-1:0] got_idx;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int i, int seed);
    return 8'(i * 7 + seed);
  endfunction

  function automatic logic [7:0] mbyte(int a);
    return mem[a / 4][8 * (a % 4) +: 8];
  endfunction

  function automatic int dadr(int idx);
    return int'(BASE) + 16 * idx;
  endfunction

  task automatic setup(int idx, logic [31:0] w0, logic [31:0] w1, int bufa);
    mem[dadr(idx) / 4] = w0;
    mem[dadr(idx) / 4 + 1] = w1;
    mem[dadr(idx) / 4 + 2] = bufa;
    mem[dadr(idx) / 4 + 3] = 32'h0;
    for (int w = 0; w < 80; w++) mem[bufa / 4 + w] = 32'hA5A5A5A5;
  endtask

  task automatic load_src(int len, int seed);
    src_n = 0;
    for (int w = 0; w < (len + 3) / 4; w++)
      for (int b = 0; b < 4; b++)
        src[w][8*b +: 8] = (4 * w + b < len) ? pat(4 * w + b, seed) : 8'hEE;
    @(negedge clk); src_rst = 1'b1;
    @(negedge clk); src_rst = 1'b0;
    src_n = (len + 3) / 4;
  endtask

  task automatic launch(int idx, int len, bit b, bit m, bit p, logic [31:0] crc);
    @(negedge clk);
    desc_idx = IDX_W'(idx); frame_len = 13'(len);
    cls_bcast = b; cls_mcast = m; cls_phys = p; crc_word = crc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic await_end();
    got_ok = 0; got_ovf = 0; got_miss = 0;
    for (int c = 0; c < 5000; c++) begin
      if (rx_ok || ovf_irq) begin
        got_ok = rx_ok; got_ovf = ovf_irq; got_miss = miss_inc; got_idx = next_idx;
        break;
      end
      @(negedge clk);
    end
    for (int c = 0; c < 5000 && busy; c++) @(negedge clk);
    chk(!busy, "R8", "engine returns idle", busy, 0);
  endtask

  task automatic verify_frame(int bufa, int len, int seed, logic [31:0] crc, string tag);
    int pl, bad_d, bad_p, bad_c;
    pl = (len < 60) ? 60 : len;
    bad_d = 0; bad_p = 0; bad_c = 0;
    for (int i = 0; i < len; i++) if (mbyte(bufa + i) !== pat(i, seed)) bad_d++;
    for (int i = len; i < pl; i++) if (mbyte(bufa + i) !== 8'h00) bad_p++;
    for (int i = 0; i < 4; i++) if (mbyte(bufa + pl + i) !== crc[8*i +: 8]) bad_c++;
    for (int i = pl + 4; i < ((pl + 7) / 4) * 4 + 4; i++) if (mbyte(bufa + i) !== 8'hA5) bad_c++;
    chk(bad_d == 0, "R4", {tag, " frame bytes"}, bad_d, 0);
    if (len < 60) chk(bad_p == 0, "R5", {tag, " zero padding"}, bad_p, 0);
    chk(bad_c == 0, "R6", {tag, " checksum and guard bytes"}, bad_c, 0);
  endtask

  function automatic logic [31:0] exp_w0(logic [31:0] w0, int len, bit b, bit m, bit p);
    int pl;
    pl = (len < 60) ? 60 : len;
    return (w0 & 32'h4FFF_E000) | 32'h3000_0000 | (32'(m) << 26) | (32'(p) << 25) |
           (32'(b) << 24) | 32'(pl + 4);
  endfunction

  task automatic t_reset();
    chk(!busy && !rx_ok && !ovf_irq && !miss_inc, "R11", "reset outputs idle",
        {busy, rx_ok, ovf_irq, miss_inc}, 0);
    chk(!mem_req && !in_ready, "R11", "reset no request", {mem_req, in_ready}, 0);
    chk(next_idx == 0, "R11", "reset next_idx", next_idx, 0);
  endtask

  task automatic t_good(int idx, int len, bit b, bit m, bit p, logic [31:0] crc,
                        logic [31:0] w0, int bufa, int seed, string tag);
    int r0, w0n;
    logic [31:0] w1;
    w1 = 32'h0001_ABCD;
    setup(idx, w0, w1, bufa);
    load_src(len, seed);
    r0 = rd_n; w0n = wr_n;
    launch(idx, len, b, m, p, crc);
    await_end();
    chk(rd_n - r0 == 4 && rd_log[r0[7:0]] == 64'(dadr(idx)) &&
        rd_log[8'(r0 + 3)] == 64'(dadr(idx) + 12), "R1", {tag, " descriptor reads"},
        rd_log[r0[7:0]], dadr(idx));
    verify_frame(bufa, len, seed, crc, tag);
    chk(mem[dadr(idx) / 4] == exp_w0(w0, len, b, m, p), "R7", {tag, " status word"},
        mem[dadr(idx) / 4], exp_w0(w0, len, b, m, p));
    chk(mem[dadr(idx) / 4 + 1] == 32'h0000_ABCD, "R7", {tag, " tag word"},
        mem[dadr(idx) / 4 + 1], 32'h0000_ABCD);
    chk(wr_log[8'(wr_n - 1)] == 64'(dadr(idx)) && wr_log[8'(wr_n - 2)] == 64'(dadr(idx) + 4),
        "R7", {tag, " write-back order"}, wr_log[8'(wr_n - 1)], dadr(idx));
    chk(got_ok && !got_ovf && !got_miss, "R8", {tag, " completion pulses"},
        {got_ok, got_ovf, got_miss}, 3'b100);
    chk(got_idx == (w0[30] ? 0 : IDX_W'(idx + 1)), "R8", {tag, " next index"},
        got_idx, w0[30] ? 0 : idx + 1);
  endtask

  task automatic t_drop(int idx, int len, logic [31:0] w0, int bufa, string req, string tag);
    int w0n;
    setup(idx, w0, 32'h0, bufa);
    load_src(len, 9);
    w0n = wr_n;
    launch(idx, len, 0, 0, 1, 32'h1234_5678);
    await_end();
    chk(wr_n == w0n, req, {tag, " no memory write"}, wr_n - w0n, 0);
    chk(got_ovf && got_miss && !got_ok, req, {tag, " drop pulses"},
        {got_ok, got_ovf, got_miss}, 3'b011);
    chk(got_idx == IDX_W'(idx), req, {tag, " index kept"}, got_idx, idx);
    chk(mem[dadr(idx) / 4] == w0, req, {tag, " descriptor untouched"}, mem[dadr(idx) / 4], w0);
    chk(src_i == src_n && !in_valid, "R9", {tag, " stream drained"}, src_i, src_n);
  endtask

  task automatic t_busy_start();
    int ok0;
    setup(10, 32'h8000_0600, 32'h0, 32'hA00);
    setup(2, 32'h8000_0600, 32'h0, 32'hC00);
    load_src(200, 3);
    ok0 = ok_n;
    launch(10, 200, 0, 1, 0, 32'hCAFE_F00D);
    repeat (10) @(negedge clk);
    launch(2, 20, 1, 0, 0, 32'h0);
    await_end();
    repeat (20) @(negedge clk);
    chk(ok_n - ok0 == 1, "R11", "one completion only", ok_n - ok0, 1);
    chk(!busy, "R11", "no second frame started", busy, 0);
    chk(mem[dadr(2) / 4] == 32'h8000_0600, "R11", "ignored descriptor untouched",
        mem[dadr(2) / 4], 32'h8000_0600);
    verify_frame(32'hA00, 200, 3, 32'hCAFE_F00D, "busy");
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_good(3, 100, 0, 1, 0, 32'hDEAD_BEEF, 32'h8080_0600, 32'h200, 1, "normal");
    t_good(4, 13, 1, 0, 0, 32'h1122_3344, 32'h8000_0600, 32'h400, 5, "short");
    t_good(5, 65, 0, 0, 1, 32'h5566_7788, 32'h8800_0600, 32'h600, 7, "partial");
    t_drop(6, 40, 32'h0000_0600, 32'h800, "R2", "not owned");
    t_drop(7, 100, 32'h8000_0000 | 32'd103, 32'h800, "R3", "too small");
    t_good(7, 100, 1, 0, 0, 32'hA1B2_C3D4, 32'h8000_0000 | 32'd104, 32'h800, 11, "exact fit R3");
    t_drop(8, 10, 32'h8000_0000 | 32'd63, 32'h800, "R3", "short too small");
    t_good(9, 64, 0, 0, 1, 32'h0F0F_0F0F, 32'hC000_0600, 32'hE00, 13, "end of ring");
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule